// File: doc/BRIEF.md
# Instruction Word Classifier and Effective-Address Resolver

This block accepts one 16-bit instruction word at a time from a fetch stage. It works out which of three instruction families the word belongs to: memory operations, register operations or input-output operations. For memory operations it also produces the 12-bit operand address. The top bit of the word selects the addressing mode, the next three bits hold the operation, and the low twelve bits hold an address or a function-select field.

In direct mode the address field is the operand address and the result is ready one cycle after the start strobe. In indirect mode the address field names a memory word that holds the real address. The block then issues one read on a synchronous memory port and waits a parameterised number of cycles for the data. It takes the low twelve bits of that data as the operand address. Register and input-output words pass their low twelve bits through unchanged as function-select bits.

The results stay on the outputs until the next decode completes. A single-cycle done pulse marks when they are valid.

Top module: `insn_decoder`

## Requirements
- R1: A word whose operation field (bits 14..12) is any value from 000 to 110 is reported as class 0 (memory), whatever the value of bit 15. The op output carries the field.
- R2: A word with operation field 111 and bit 15 = 0 is reported as class 1 (register). Its bits 11..0 appear unchanged on ea.
- R3: A word with operation field 111 and bit 15 = 1 is reported as class 2 (input-output). Its bits 11..0 appear unchanged on ea.
- R4: For a memory word with bit 15 = 0, ea equals bits 11..0. done is high in the cycle after start is sampled, and no memory read is issued.
- R5: For a memory word with bit 15 = 1, mem_rd is high for exactly one cycle, starting in the cycle after start is sampled, with mem_addr equal to bits 11..0.
- R6: For an indirect word, ea equals bits 11..0 of the word read back, and the upper four bits of that word have no effect. done rises MEM_LAT+1 cycles after start is sampled.
- R7: A start strobe that arrives while a pointer read is pending is ignored. It does not change the result, its timing or the number of reads.
- R8: done is a single pulse per accepted word. cls, op and ea change only in cycles where done is high.
- R9: While rst_n is low, done, mem_rd, cls, op, ea and mem_addr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Strobe: instr is valid this cycle |
| instr | input | 16 | Instruction word |
| mem_rd | output | 1 | Pointer read request |
| mem_addr | output | 12 | Pointer read address |
| mem_rdata | input | 16 | Read data, valid MEM_LAT cycles after the request is sampled |
| cls | output | 2 | Class: 0 memory, 1 register, 2 input-output |
| op | output | 3 | Operation field |
| ea | output | 12 | Effective address or function-select bits |
| done | output | 1 | Results valid pulse |

## Verification
The bench builds the block with AW = 12 and MEM_LAT = 3, not the default latency of 1. This gives the pointer wait several idle cycles. In those cycles the bench can confirm that done stays low, that mem_rd does not repeat, and that an extra start strobe is dropped. The memory model returns words with non-zero upper bits, so R6's masking is checked on every indirect access.

// File: rtl/insn_decoder.sv
module insn_decoder #(
  parameter int AW      = 12,
  parameter int MEM_LAT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW+3:0] instr,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [AW+3:0] mem_rdata,
  output logic [1:0]    cls,
  output logic [2:0]    op,
  output logic [AW-1:0] ea,
  output logic          done
);
  localparam int DW = AW + 4;
  localparam int CW = (MEM_LAT < 1) ? 1 : $clog2(MEM_LAT + 1);
  localparam logic [1:0] C_MEM = 2'd0, C_REG = 2'd1, C_IO = 2'd2;

  logic          pend;
  logic [CW-1:0] cnt;
  logic [2:0]    pop;

  wire       mode    = instr[DW-1];
  wire [2:0] opf     = instr[DW-2 -: 3];
  wire       is_mem  = opf != 3'b111;
  wire       take    = start & ~pend;
  wire       go_ind  = take & is_mem & mode;
  wire       fetched = pend && (cnt == CW'(MEM_LAT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      cnt      <= '0;
      pop      <= '0;
      mem_rd   <= 1'b0;
      mem_addr <= '0;
      cls      <= C_MEM;
      op       <= '0;
      ea       <= '0;
      done     <= 1'b0;
    end else begin
      done   <= 1'b0;
      mem_rd <= 1'b0;
      if (go_ind) begin
        pend     <= 1'b1;
        cnt      <= '0;
        pop      <= opf;
        mem_rd   <= 1'b1;
        mem_addr <= instr[AW-1:0];
      end else if (take) begin
        op   <= opf;
        cls  <= is_mem ? C_MEM : (mode ? C_IO : C_REG);
        ea   <= instr[AW-1:0];
        done <= 1'b1;
      end else if (fetched) begin
        op   <= pop;
        cls  <= C_MEM;
        ea   <= mem_rdata[AW-1:0];
        done <= 1'b1;
        pend <= 1'b0;
      end else if (pend) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/insn_decoder_chk.sv
module insn_decoder_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW+3:0] instr,
  input logic          pend,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    cls,
  input logic [2:0]    op,
  input logic [AW-1:0] ea,
  input logic          done
);
  wire [2:0] f = instr[AW+2:AW];
  wire       m = instr[AW+3];

  a_r4_direct_done: assert property (@(posedge clk) disable iff (!rst_n)
    start && !pend && !(m && f != 3'b111) |=> done && !mem_rd && ea == $past(instr[AW-1:0]));
  a_r5_ptr_read: assert property (@(posedge clk) disable iff (!rst_n)
    start && !pend && m && f != 3'b111 |=> mem_rd && !done && mem_addr == $past(instr[AW-1:0]));
  a_r5_read_once: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  a_r1_mem_class: assert property (@(posedge clk) disable iff (!rst_n)
    done && op != 3'b111 |-> cls == 2'd0);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(ea) && $stable(cls) && $stable(op));
  a_r9_reset: assert property (@(posedge clk)
    !rst_n |=> !done && !mem_rd);
endmodule

bind insn_decoder insn_decoder_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pend(pend),
  .mem_rd(mem_rd), .mem_addr(mem_addr), .cls(cls), .op(op), .ea(ea), .done(done)
);

// File: tb/insn_decoder_test.sv
`timescale 1ns/1ps
module insn_decoder_test;
  localparam int AW  = 12;
  localparam int LAT = 3;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          start = 0;
  logic [15:0]   instr = '0;
  logic          mem_rd;
  logic [11:0]   mem_addr;
  logic [15:0]   mem_rdata;
  logic [1:0]    cls;
  logic [2:0]    op;
  logic [11:0]   ea;
  logic          done;

  int tests = 0, fails = 0, rd_count = 0;

  always #2 clk = ~clk;

  insn_decoder #(.AW(AW), .MEM_LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .cls(cls), .op(op), .ea(ea), .done(done));

  function automatic logic [15:0] mfun(input logic [11:0] a);
    return {~a[3:0] | 4'h1, a ^ 12'hC35};
  endfunction

  logic [15:0] pipe [LAT];
  always @(posedge clk) begin
    pipe[0] <= mem_rd ? mfun(mem_addr) : 16'hFFFF;
    for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
    if (mem_rd) rd_count <= rd_count + 1;
  end
  assign mem_rdata = pipe[LAT-1];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] w);
    @(negedge clk); start = 1; instr = w;
    @(posedge clk); @(negedge clk); start = 0;
  endtask

  task automatic t_reset;
    check(done == 0 && mem_rd == 0, "R9 strobes", {done, mem_rd}, 0);
    check(cls == 0 && op == 0 && ea == 0 && mem_addr == 0, "R9 outputs", {cls, op, ea}, 0);
  endtask

  task automatic t_direct(input logic [2:0] o, input logic [11:0] a);
    int r0 = rd_count;
    issue({1'b0, o, a});
    check(done == 1, "R4 done timing", done, 1);
    check(ea == a, "R4 ea", ea, a);
    check(cls == 0 && op == o, "R1 class/op", {cls, op}, {2'd0, o});
    @(negedge clk);
    check(rd_count == r0 && done == 0, "R4 no read / R8 pulse", rd_count - r0, 0);
  endtask

  task automatic t_rr(input logic i, input logic [11:0] a);
    logic [1:0] ec = i ? 2'd2 : 2'd1;
    issue({i, 3'b111, a});
    check(done == 1 && cls == ec, i ? "R3 io class" : "R2 reg class", cls, ec);
    check(ea == a && op == 3'b111, i ? "R3 bits pass" : "R2 bits pass", ea, a);
  endtask

  task automatic t_indirect(input logic [2:0] o, input logic [11:0] a, input bit extra);
    int r0 = rd_count;
    logic [11:0] old = ea;
    logic [15:0] w = mfun(a);
    issue({1'b1, o, a});
    check(mem_rd == 1 && mem_addr == a, "R5 read request", mem_addr, a);
    check(done == 0 && ea == old, "R8 held during wait", ea, old);
    for (int k = 1; k <= LAT; k++) begin
      if (extra && k == 1) begin
        start = 1; instr = {1'b0, 3'b010, 12'h0AA};
      end
      @(posedge clk); @(negedge clk);
      start = 0;
      check(done == 0 && mem_rd == 0, extra ? "R7 no early done" : "R5 single pulse", {done, mem_rd}, 0);
    end
    @(posedge clk); @(negedge clk);
    check(done == 1, "R6 done timing", done, 1);
    check(ea == w[11:0], extra ? "R7 ea unaffected" : "R6 ea from pointer", ea, w[11:0]);
    check(cls == 0 && op == o, "R1 indirect class/op", {cls, op}, {2'd0, o});
    check(rd_count - r0 == 1, "R5 one read", rd_count - r0, 1);
    @(negedge clk);
    check(done == 0 && ea == w[11:0], "R8 pulse and hold", {done, ea}, {1'b0, w[11:0]});
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1;
    for (int o = 0; o < 7; o++) t_direct(3'(o), 12'(12'h111 * o + 12'h00F));
    t_direct(3'b000, 12'hFFF);
    t_rr(1'b0, 12'h800);
    t_rr(1'b0, 12'h001);
    t_rr(1'b1, 12'h400);
    t_rr(1'b1, 12'h040);
    t_indirect(3'b001, 12'h123, 1'b0);
    t_indirect(3'b110, 12'hFFF, 1'b0);
    t_indirect(3'b000, 12'h000, 1'b1);
    t_direct(3'b100, 12'h5A5);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule